// File: doc/BRIEF.md
# At-Speed Scan Clock Controller

This block drives the single clock of a scan-tested logic region. In scan mode it has two jobs. While scan data moves through the chains, the region is clocked from a slow test clock that arrives on a primary input. Once shifting ends, it releases a short burst of fast pulses taken from the internal PLL clock, so that the launch and capture cycles run at the functional rate. Outside scan mode the PLL clock reaches the region unchanged and the capture logic does nothing.

A scan vector runs like this. The tester shifts with `scan_en` high and `test_clk` running. It then lowers `scan_en` and raises `cap_trig`. The controller brings the trigger into the PLL domain through a two-flop synchronizer and waits for a guard gap. On a rising edge of the trigger it lets through exactly two consecutive PLL pulses: the first launches and the second captures. A `done` flag then rises. No further fast pulse appears until `scan_en` has been raised and lowered again.

Both clock sources pass through latch-based gates. Each latch is transparent only while its own clock is low. Before a burst is released, both gates stay closed for at least one cycle of each clock.

Top module: `atspeed_clk_ctrl`

## Requirements
- R1: With `scan_mode` low, `clk_out` equals `pll_clk` in both phases, `busy` and `done` stay 0, and `cap_trig` has no effect.
- R2: With `scan_mode` and `scan_en` high, `clk_out` follows `test_clk` pulse for pulse, and no PLL pulse appears.
- R3: After `scan_en` falls, `clk_out` stays low until `cap_trig` shows a rising edge. A trigger that was already high while `scan_en` was high starts no burst.
- R4: A trigger rising edge in the capture phase yields exactly two `clk_out` pulses, one PLL period apart.
- R5: `busy` is 1 while the burst is in progress, is 0 while idle or waiting, and returns to 0 once `done` is set.
- R6: `done` rises one PLL period after the rising edge of the last burst pulse. It stays high, and further trigger edges give no pulse, until `scan_en` is raised again.
- R7: Raising and lowering `scan_en` clears `done` and re-arms the controller, so that a new trigger gives another two-pulse burst.
- R8: During and after reset with `scan_mode` high and `scan_en` low, `busy` and `done` are 0 and `clk_out` shows no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low asynchronous reset of the PLL-domain logic |
| test_clk | input | 1 | Slow shift clock from a primary input |
| pll_clk | input | 1 | Fast functional clock from the internal PLL |
| scan_mode | input | 1 | Static scan-test mode select |
| scan_en | input | 1 | High while shifting, low for launch and capture |
| cap_trig | input | 1 | Rising edge requests the at-speed burst |
| clk_out | output | 1 | Clock for the scanned flops |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Burst finished for this vector |

## Verification
The bench applies four patterns. The first is functional mode with the trigger toggling, which shows whether the PLL clock passes through while the sequencer stays quiet. The second is a shift window in which the trigger is raised and held, which separates slow gating from any leak of fast pulses and from a level-sensitive trigger. The third is a clean trigger edge after shifting, whose pulse count, pulse spacing and `done` timing expose an off-by-one in the burst length or in the flag timing. The fourth is repeated triggers followed by a full re-arm, which shows whether the one-burst-per-vector lock holds and whether it can be released.

// File: rtl/atc_pkg.sv
`timescale 1ns/1ps
package atc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_WAIT,
    ST_BURST,
    ST_TAIL,
    ST_DONE
  } cap_state_e;

  // True when a zero-based counter sits on the last step of a run of lim steps.
  function automatic logic at_last(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/sync_chain.sv
`timescale 1ns/1ps
module sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/clk_gate_latch.sv
`timescale 1ns/1ps
module clk_gate_latch (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_held;

  // Enable may change only while the clock is low, so gclk has no runt pulse.
  always_latch begin
    if (!clk) en_held = en;
  end

  assign gclk = clk & en_held;
endmodule

// File: rtl/burst_seq.sv
`timescale 1ns/1ps
module burst_seq
  import atc_pkg::*;
#(
  parameter int BURST_LEN   = 2,
  parameter int GAP_CYCLES  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_mode,
  input  logic scan_en,
  input  logic cap_trig,
  output logic fast_en,
  output logic busy,
  output logic done
);
  localparam int MAXC = (BURST_LEN > GAP_CYCLES) ? BURST_LEN : GAP_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  cap_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic se_s, trig_s, trig_q, trig_rise;

  sync_chain #(.STAGES(SYNC_STAGES)) u_se_sync (
    .clk(clk), .rst_n(rst_n), .d(scan_en), .q(se_s));
  sync_chain #(.STAGES(SYNC_STAGES)) u_tr_sync (
    .clk(clk), .rst_n(rst_n), .d(cap_trig), .q(trig_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_s;
  end

  assign trig_rise = trig_s & ~trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (!scan_mode) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (!se_s) begin state_q <= ST_GAP; cnt_q <= '0; end
        ST_GAP: begin
          if (se_s) state_q <= ST_IDLE;
          else if (at_last(32'(cnt_q), GAP_CYCLES)) begin state_q <= ST_WAIT; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_WAIT: begin
          if (se_s) state_q <= ST_IDLE;
          else if (trig_rise) begin state_q <= ST_BURST; cnt_q <= '0; end
        end
        ST_BURST: begin
          if (at_last(32'(cnt_q), BURST_LEN)) state_q <= ST_TAIL;
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_TAIL: state_q <= ST_DONE;
        ST_DONE: if (se_s) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fast_en = (state_q == ST_BURST);
  assign busy    = (state_q == ST_BURST) || (state_q == ST_TAIL);
  assign done    = (state_q == ST_DONE);

  // Checker state: enabled fast cycles since scan_en was last seen high.
  logic [CW:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= '0;
    else if (se_s)    seen_q <= '0;
    else if (fast_en) seen_q <= seen_q + 1'b1;
  end

  assert_burst_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(seen_q) <= BURST_LEN);
  assert_no_fast_in_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    se_s |-> !fast_en);
  assert_func_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_mode |=> (!busy && !done));
  assert_done_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !se_s && scan_mode) |=> done);
  assert_done_after_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fast_en, 2));
  assert_busy_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/atspeed_clk_ctrl.sv
`timescale 1ns/1ps
module atspeed_clk_ctrl #(
  parameter int BURST_LEN   = 2,
  parameter int GAP_CYCLES  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic rst_n,
  input  logic test_clk,
  input  logic pll_clk,
  input  logic scan_mode,
  input  logic scan_en,
  input  logic cap_trig,
  output logic clk_out,
  output logic busy,
  output logic done
);
  logic slow_en, fast_en, slow_g, fast_g;

  assign slow_en = scan_mode & scan_en;

  burst_seq #(
    .BURST_LEN(BURST_LEN), .GAP_CYCLES(GAP_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_seq (
    .clk(pll_clk), .rst_n(rst_n), .scan_mode(scan_mode), .scan_en(scan_en),
    .cap_trig(cap_trig), .fast_en(fast_en), .busy(busy), .done(done));

  clk_gate_latch u_slow_gate (.clk(test_clk), .en(slow_en), .gclk(slow_g));
  clk_gate_latch u_fast_gate (.clk(pll_clk),  .en(fast_en), .gclk(fast_g));

  assign clk_out = scan_mode ? (slow_g | fast_g) : pll_clk;

  // Break-before-make: the fast gate is never open while shifting is requested.
  assert_break_before_make_R3: assert property (@(posedge pll_clk) disable iff (!rst_n)
    fast_en |-> !(scan_en && $past(scan_en)));
endmodule

// File: tb/atspeed_clk_ctrl_test.sv
`timescale 1ns/1ps
module atspeed_clk_ctrl_test;
  logic rst_n = 1'b0, test_clk = 1'b0, pll_clk = 1'b0;
  logic scan_mode = 1'b1, scan_en = 1'b0, cap_trig = 1'b0;
  logic clk_out, busy, done;

  int checks = 0, errors = 0;
  int edges = 0, base = 0;
  longint t_prev = 0, t_last = 0, t_done = 0;
  int cyc = 0;

  atspeed_clk_ctrl uut (
    .rst_n(rst_n), .test_clk(test_clk), .pll_clk(pll_clk), .scan_mode(scan_mode),
    .scan_en(scan_en), .cap_trig(cap_trig), .clk_out(clk_out), .busy(busy), .done(done));

  always #2  pll_clk  = ~pll_clk;   // 250 MHz
  always #20 test_clk = ~test_clk;

  always @(posedge clk_out) begin
    edges++;
    t_prev = t_last;
    t_last = $time;
  end
  always @(posedge done) t_done = $time;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pll(input int n);
    for (int i = 0; i < n; i++) @(posedge pll_clk);
  endtask

  always @(posedge pll_clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8: reset state in scan mode, capture phase, no trigger
    wait_pll(5);
    check("R8 busy in reset", busy, 0);
    check("R8 done in reset", done, 0);
    @(negedge pll_clk); rst_n = 1'b1;
    base = edges;
    wait_pll(15);
    check("R8 no pulse after reset", edges - base, 0);
    check("R8 busy after reset", busy, 0);
    check("R8 done after reset", done, 0);

    // R1: functional mode passes the PLL clock, trigger ignored
    @(negedge pll_clk); scan_mode = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(posedge pll_clk); #1;
      check("R1 clk_out high phase", clk_out, 1);
      cap_trig = (i % 4) < 2;
      #2;
      check("R1 clk_out low phase", clk_out, 0);
      check("R1 busy stays low", busy, 0);
      check("R1 done stays low", done, 0);
    end
    cap_trig = 1'b0;
    @(negedge pll_clk); scan_mode = 1'b1;
    wait_pll(8);

    // R2: shifting follows test_clk, trigger raised and held during shift
    @(negedge test_clk); #5; scan_en = 1'b1;
    base = edges;
    for (int i = 0; i < 4; i++) begin
      @(posedge test_clk); #10;
      check("R2 shift high phase", clk_out, 1);
      if (i == 1) cap_trig = 1'b1;
      @(negedge test_clk); #10;
      check("R2 shift low phase", clk_out, 0);
    end
    check("R2 shift pulse count", edges - base, 4);

    // R3: leave shift with trigger already high: no burst
    #5; scan_en = 1'b0;
    base = edges;
    wait_pll(25);
    check("R3 held trigger gives no pulse", edges - base, 0);
    check("R3 busy while waiting", busy, 0);
    @(negedge pll_clk); cap_trig = 1'b0;
    wait_pll(6);
    check("R3 still no pulse", edges - base, 0);

    // R4/R5/R6: clean trigger edge
    @(negedge pll_clk); cap_trig = 1'b1;
    @(posedge clk_out); #1;
    check("R5 busy during burst", busy, 1);
    wait_pll(20);
    check("R4 burst pulse count", edges - base, 2);
    check("R4 pulse spacing ns", t_last - t_prev, 4);
    check("R6 done set", done, 1);
    check("R5 busy clear after burst", busy, 0);
    check("R6 done one period after last pulse", t_done - t_last, 4);

    // R6: more trigger edges are locked out
    for (int k = 0; k < 2; k++) begin
      @(negedge pll_clk); cap_trig = 1'b0;
      wait_pll(6);
      @(negedge pll_clk); cap_trig = 1'b1;
      wait_pll(12);
    end
    check("R6 no extra pulse", edges - base, 2);
    check("R6 done held", done, 1);
    cap_trig = 1'b0;

    // R7: re-arm through a shift window
    @(negedge test_clk); #5; scan_en = 1'b1;
    base = edges;
    @(posedge test_clk); @(posedge test_clk); #10;
    check("R7 done cleared by shift", done, 0);
    check("R7 shift pulses during re-arm", edges - base, 2);
    @(negedge test_clk); #5; scan_en = 1'b0;
    base = edges;
    wait_pll(10);
    check("R7 quiet before trigger", edges - base, 0);
    @(negedge pll_clk); cap_trig = 1'b1;
    wait_pll(20);
    check("R7 second burst count", edges - base, 2);
    check("R7 second burst spacing", t_last - t_prev, 4);
    check("R7 done again", done, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule